// File: doc/BRIEF.md
# Smartcard Character Transmitter with Automatic Retry

This block serialises one byte at a time onto the half-duplex I/O line of a contact smartcard. It sends a low start bit, eight data bits with the least significant first, and an even parity bit. It then releases the line for a guard period. The guard period is two stop ETUs when the T=0 protocol is selected and one stop ETU under T=1. During the guard period the card may pull the line low to report a parity error. When that happens and retries remain, the block waits two ETUs and sends the same character again. When no retries are left, it raises a sticky transmit-error flag and drops the character.

Bit timing comes from an external tick that pulses once per half ETU. Each bit therefore spans two ticks, and the error check falls on the first tick of the guard period, which is the middle of the first stop ETU. The open-drain line appears as a drive-low output and a sense input. The sense input passes through a synchroniser.

The retry setting is held as the requested count minus one, together with a separate enable bit. A clear enable bit means zero retries. A configuration write takes effect a fixed number of cycles after it is accepted, and a busy output covers that interval. The count field cannot be changed while retry is enabled, so software clears the enable bit before it loads a new count.

Top module: `sct_char_tx`

## Requirements
- R1: After reset the line is released (line_drive_low=0), tx_ready=1, tx_done=0, tx_err=0 and cfg_busy=0. The effective configuration after reset is retry disabled, count field 0 and T=0 (two stop ETUs).
- R2: An accepted byte is sent as frame bit 0 = start (line driven low), bits 1..8 = data[0]..data[7], and bit 9 = even parity (the XOR of the data bits). Each frame bit lasts two half-ETU ticks, and the start bit begins in the cycle after acceptance.
- R3: After the parity bit the line is released for the guard period: 4 ticks when cfg_single_stop=0 and 2 ticks when it is 1. With no error, tx_done pulses for one cycle after the last guard tick and tx_ready returns high.
- R4: The line level is taken on the first guard tick. A low level there marks the attempt as failed, and a low level at any other time has no effect.
- R5: After a failed attempt with retries remaining, the line stays released for a pause of 4 ticks. The full frame is then resent, and at most the configured number of resends (up to 8) takes place.
- R6: The effective retry count is the stored field plus one when the enable bit is 1, and 0 when it is 0. With retry disabled, a failed attempt is never resent.
- R7: An applied configuration write leaves the count field unchanged while the effective enable bit is 1. The enable bit and the stop-length bit are still updated by that write.
- R8: An accepted configuration write holds cfg_busy high for SYNC_LAT cycles (default 2), and the write takes effect when cfg_busy falls. A write presented while cfg_busy is high is ignored.
- R9: A failed attempt with no retries left sets tx_err and pulses tx_done, and the character is dropped. tx_err stays set through later characters until err_clr is pulsed.
- R10: A byte is accepted only when tx_valid and tx_ready are both high. tx_ready stays low from acceptance through every retry pause until the final tx_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter idle, byte accepted this cycle if valid |
| half_etu_tick | input | 1 | One-cycle pulse every half ETU |
| line_drive_low | output | 1 | 1 pulls the I/O line low, 0 releases it |
| line_sense | input | 1 | Level observed on the I/O line |
| tx_done | output | 1 | One-cycle pulse when a character finishes or is dropped |
| tx_err | output | 1 | Sticky flag: a character was dropped after its last retry |
| err_clr | input | 1 | Clears tx_err |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_retry_en | input | 1 | Retry enable bit to write |
| cfg_retry_m1 | input | 3 | Retry count minus one to write |
| cfg_single_stop | input | 1 | 1 selects one stop ETU (T=1), 0 selects two (T=0) |
| cfg_busy | output | 1 | A configuration write is still being applied |

## Verification
A corrupted bit counter or frame register appears on line_drive_low as a wrong level within two ticks of the bit that holds it, and a wrong guard length moves the tx_done pulse by whole ticks. A wrong remaining-retry count or a locked field that fails to hold shows up only at the end of the last attempt. At that point tx_err and tx_done arrive one attempt too early or too late, so the bench counts resends for every character. A configuration applied too early or too late shows as a cfg_busy width that differs from SYNC_LAT cycles.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int MAX_RETRY = 8;
  localparam int RETRY_W   = $clog2(MAX_RETRY);
  localparam int LEFT_W    = RETRY_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_GUARD = 2'd2,
    ST_PAUSE = 2'd3
  } tx_state_e;
endpackage

// File: rtl/sct_cfg_sync.sv
module sct_cfg_sync
  import sct_pkg::*;
#(
  parameter int SYNC_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              en_i,
  input  logic [RETRY_W-1:0] m1_i,
  input  logic              single_i,
  output logic              busy_o,
  output logic [LEFT_W-1:0] retries_o,
  output logic              single_o
);
  localparam int CNT_W = $clog2(SYNC_LAT + 1);

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               st_en_q, st_en_d, st_single_q, st_single_d;
  logic [RETRY_W-1:0] st_m1_q, st_m1_d;
  logic               eff_en_q, eff_en_d, eff_single_q, eff_single_d;
  logic [RETRY_W-1:0] eff_m1_q, eff_m1_d;
  logic               accept, apply;

  assign accept = we_i && (cnt_q == '0);
  assign apply  = (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d        = cnt_q;
    st_en_d      = st_en_q;
    st_m1_d      = st_m1_q;
    st_single_d  = st_single_q;
    eff_en_d     = eff_en_q;
    eff_m1_d     = eff_m1_q;
    eff_single_d = eff_single_q;
    if (accept) begin
      cnt_d       = CNT_W'(SYNC_LAT);
      st_en_d     = en_i;
      st_m1_d     = m1_i;
      st_single_d = single_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
    if (apply) begin
      eff_en_d     = st_en_q;
      eff_single_d = st_single_q;
      if (!eff_en_q) eff_m1_d = st_m1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      st_en_q      <= 1'b0;
      st_m1_q      <= '0;
      st_single_q  <= 1'b0;
      eff_en_q     <= 1'b0;
      eff_m1_q     <= '0;
      eff_single_q <= 1'b0;
    end else begin
      cnt_q        <= cnt_d;
      st_en_q      <= st_en_d;
      st_m1_q      <= st_m1_d;
      st_single_q  <= st_single_d;
      eff_en_q     <= eff_en_d;
      eff_m1_q     <= eff_m1_d;
      eff_single_q <= eff_single_d;
    end
  end

  assign busy_o    = (cnt_q != '0);
  assign retries_o = eff_en_q ? ({1'b0, eff_m1_q} + LEFT_W'(1)) : '0;
  assign single_o  = eff_single_q;

  // R8: the effective setting moves only on the cycle the busy window closes
  p_apply_at_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != CNT_W'(1)) |=> ($stable(eff_en_q) && $stable(eff_m1_q) && $stable(eff_single_q)));

  // R7: count field is frozen while retry is enabled
  p_field_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_en_q |=> $stable(eff_m1_q));

  // R8: busy rises only from an accepted write, at full length
  p_busy_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (cnt_q == CNT_W'(SYNC_LAT)));
endmodule

// File: rtl/sct_line_sync.sv
module sct_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic q;
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b1;
        else         q <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b1;
        else         q <= g_stage[i-1].q;
      end
    end
  end

  assign q_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/sct_tx_engine.sv
module sct_tx_engine
  import sct_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PAUSE_ETU = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              tick_i,
  input  logic              sense_i,
  input  logic [LEFT_W-1:0] retries_i,
  input  logic              single_stop_i,
  input  logic              err_clr_i,
  output logic              drive_low_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int FRAME_BITS   = DATA_W + 2;
  localparam int FRAME_HALVES = 2 * FRAME_BITS;
  localparam int PAUSE_HALVES = 2 * PAUSE_ETU;
  localparam int CNT_W        = $clog2(FRAME_HALVES);

  tx_state_e             state_q, state_d;
  logic [CNT_W-1:0]      hcnt_q, hcnt_d;
  logic [FRAME_BITS-1:0] frame_q, frame_d;
  logic [LEFT_W-1:0]     left_q, left_d;
  logic                  stop2_q, stop2_d;
  logic                  seen_q, seen_d;
  logic                  done_q, done_d;
  logic                  err_q, err_d;
  logic [CNT_W-1:0]      guard_last;

  assign guard_last = stop2_q ? CNT_W'(3) : CNT_W'(1);

  always_comb begin
    state_d = state_q;
    hcnt_d  = hcnt_q;
    frame_d = frame_q;
    left_d  = left_q;
    stop2_d = stop2_q;
    seen_d  = seen_q;
    done_d  = 1'b0;
    err_d   = err_q & ~err_clr_i;
    unique case (state_q)
      ST_IDLE: begin
        if (valid_i) begin
          frame_d = {^data_i, data_i, 1'b0};
          left_d  = retries_i;
          stop2_d = ~single_stop_i;
          hcnt_d  = '0;
          state_d = ST_FRAME;
        end
      end
      ST_FRAME: begin
        if (tick_i) begin
          if (hcnt_q == CNT_W'(FRAME_HALVES - 1)) begin
            hcnt_d  = '0;
            seen_d  = 1'b0;
            state_d = ST_GUARD;
          end else begin
            hcnt_d = hcnt_q + CNT_W'(1);
          end
        end
      end
      ST_GUARD: begin
        if (tick_i) begin
          if (hcnt_q == '0) seen_d = ~sense_i;
          if (hcnt_q == guard_last) begin
            hcnt_d = '0;
            if (seen_q && (left_q != '0)) begin
              left_d  = left_q - LEFT_W'(1);
              state_d = ST_PAUSE;
            end else begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
              if (seen_q) err_d = 1'b1;
            end
          end else begin
            hcnt_d = hcnt_q + CNT_W'(1);
          end
        end
      end
      ST_PAUSE: begin
        if (tick_i) begin
          if (hcnt_q == CNT_W'(PAUSE_HALVES - 1)) begin
            hcnt_d  = '0;
            state_d = ST_FRAME;
          end else begin
            hcnt_d = hcnt_q + CNT_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hcnt_q  <= '0;
      frame_q <= '1;
      left_q  <= '0;
      stop2_q <= 1'b1;
      seen_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hcnt_q  <= hcnt_d;
      frame_q <= frame_d;
      left_q  <= left_d;
      stop2_q <= stop2_d;
      seen_q  <= seen_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign ready_o     = (state_q == ST_IDLE);
  assign drive_low_o = (state_q == ST_FRAME) && !frame_q[hcnt_q[CNT_W-1:1]];
  assign done_o      = done_q;
  assign err_o       = err_q;

  // R5: remaining retries never grow within a character
  p_retry_monotonic_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (left_q <= $past(left_q)));

  // R3: the completion pulse coincides with an idle, ready transmitter
  p_done_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (ready_o && !drive_low_o));

  // R9: the error flag stays until it is cleared
  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !err_clr_i) |=> err_q);

  // R3: single-stop guard never runs past two ticks
  p_guard_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_GUARD) && !stop2_q) |-> (hcnt_q <= CNT_W'(1)));

  // R10: the held frame cannot change while a character is in flight
  p_frame_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(frame_q));
endmodule

// File: rtl/sct_char_tx.sv
module sct_char_tx
  import sct_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_LAT    = 2,
  parameter int SENSE_SYNC  = 2,
  parameter int PAUSE_ETU   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              half_etu_tick,
  output logic              line_drive_low,
  input  logic              line_sense,
  output logic              tx_done,
  output logic              tx_err,
  input  logic              err_clr,
  input  logic              cfg_we,
  input  logic              cfg_retry_en,
  input  logic [RETRY_W-1:0] cfg_retry_m1,
  input  logic              cfg_single_stop,
  output logic              cfg_busy
);
  logic rst_meta_q, rst_sync_q;
  logic sense_s;
  logic [LEFT_W-1:0] retries;
  logic single_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sct_line_sync #(.STAGES(SENSE_SYNC)) u_sense (
    .clk_i  (clk),
    .rst_ni (rst_sync_q),
    .d_i    (line_sense),
    .q_o    (sense_s)
  );

  sct_cfg_sync #(.SYNC_LAT(SYNC_LAT)) u_cfg (
    .clk_i     (clk),
    .rst_ni    (rst_sync_q),
    .we_i      (cfg_we),
    .en_i      (cfg_retry_en),
    .m1_i      (cfg_retry_m1),
    .single_i  (cfg_single_stop),
    .busy_o    (cfg_busy),
    .retries_o (retries),
    .single_o  (single_stop)
  );

  sct_tx_engine #(.DATA_W(DATA_W), .PAUSE_ETU(PAUSE_ETU)) u_eng (
    .clk_i         (clk),
    .rst_ni        (rst_sync_q),
    .data_i        (tx_data),
    .valid_i       (tx_valid),
    .ready_o       (tx_ready),
    .tick_i        (half_etu_tick),
    .sense_i       (sense_s),
    .retries_i     (retries),
    .single_stop_i (single_stop),
    .err_clr_i     (err_clr),
    .drive_low_o   (line_drive_low),
    .done_o        (tx_done),
    .err_o         (tx_err)
  );
endmodule

// File: tb/tb_sct_char_tx.sv
module tb_sct_char_tx;
  localparam int SYNC_LAT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       half_etu_tick = 1'b0;
  logic       line_drive_low;
  logic       line_sense;
  logic       tx_done;
  logic       tx_err;
  logic       err_clr = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_retry_en = 1'b0;
  logic [2:0] cfg_retry_m1 = '0;
  logic       cfg_single_stop = 1'b0;
  logic       cfg_busy;
  logic       card_pull = 1'b0;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;
  bit  saw_done;
  bit  m_en = 0, m_single = 0, m_err = 0;
  int  m_m1 = 0;

  always #4 clk = ~clk;

  assign line_sense = ~(line_drive_low | card_pull);

  sct_char_tx #(.SYNC_LAT(SYNC_LAT)) dut (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .half_etu_tick(half_etu_tick),
    .line_drive_low(line_drive_low), .line_sense(line_sense),
    .tx_done(tx_done), .tx_err(tx_err), .err_clr(err_clr),
    .cfg_we(cfg_we), .cfg_retry_en(cfg_retry_en), .cfg_retry_m1(cfg_retry_m1),
    .cfg_single_stop(cfg_single_stop), .cfg_busy(cfg_busy)
  );

  function automatic bit exp_bit(input logic [7:0] d, input int k);
    if (k == 0) return 1'b0;
    if (k == 9) return ^d;
    return d[k-1];
  endfunction

  function automatic int exp_retries();
    return m_en ? m_m1 + 1 : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick1();
    repeat (3) @(negedge clk);
    half_etu_tick = 1'b1;
    @(negedge clk);
    half_etu_tick = 1'b0;
    saw_done = tx_done;
  endtask

  task automatic cfg_write(input bit en, input int m1, input bit single);
    while (cfg_busy) @(negedge clk);
    cfg_we = 1'b1; cfg_retry_en = en; cfg_retry_m1 = 3'(m1); cfg_single_stop = single;
    @(negedge clk);
    cfg_we = 1'b0;
    for (int i = 0; i < SYNC_LAT; i++) begin
      chk(cfg_busy == 1'b1, "R8", "busy during apply", cfg_busy, 1);
      @(negedge clk);
    end
    chk(cfg_busy == 1'b0, "R8", "busy after apply", cfg_busy, 0);
    m_single = single;
    if (!m_en) m_m1 = m1;
    m_en = en;
  endtask

  // second write lands while busy and must be dropped
  task automatic cfg_write_pair(input bit en, input int m1, input bit single,
                                input bit en2, input int m2, input bit single2);
    while (cfg_busy) @(negedge clk);
    cfg_we = 1'b1; cfg_retry_en = en; cfg_retry_m1 = 3'(m1); cfg_single_stop = single;
    @(negedge clk);
    cfg_retry_en = en2; cfg_retry_m1 = 3'(m2); cfg_single_stop = single2;
    chk(cfg_busy == 1'b1, "R8", "busy at second write", cfg_busy, 1);
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (SYNC_LAT + 2) @(negedge clk);
    chk(cfg_busy == 1'b0, "R8", "busy settled", cfg_busy, 0);
    m_single = single;
    if (!m_en) m_m1 = m1;
    m_en = en;
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    m_err = 0;
    chk(tx_err == 1'b0, "R9", "error cleared", tx_err, 0);
  endtask

  task automatic send_char(input logic [7:0] d, input logic [8:0] errmask);
    int retries = exp_retries();
    int resends = 0;
    bit single = m_single;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R10", "ready before offer", tx_ready, 1);
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R10", "ready after accept", tx_ready, 0);
    for (int a = 0; a <= retries; a++) begin
      bit e = errmask[a];
      for (int k = 0; k < 10; k++) begin
        chk(line_drive_low == !exp_bit(d, k), "R2", $sformatf("frame bit %0d", k),
            line_drive_low, !exp_bit(d, k));
        // a stray low in the frame must not count as an error
        if (k == 5) card_pull = 1'b1;
        tick1();
        card_pull = 1'b0;
        tick1();
      end
      chk(line_drive_low == 1'b0, "R3", "line released in guard", line_drive_low, 0);
      card_pull = e;
      tick1();
      tick1();
      card_pull = 1'b0;
      if (!single) begin
        chk(saw_done == 1'b0, "R3", "no done before second stop", saw_done, 0);
        tick1();
        tick1();
      end
      if (!e) begin
        chk(saw_done == 1'b1, "R3", "done after guard", saw_done, 1);
        chk(tx_ready == 1'b1, "R3", "ready after done", tx_ready, 1);
        chk(tx_err == m_err, "R9", "sticky flag on success", tx_err, m_err);
        break;
      end
      if (a == retries) begin
        m_err = 1;
        chk(saw_done == 1'b1, "R9", "done on drop", saw_done, 1);
        chk(tx_err == 1'b1, "R9", "error set on drop", tx_err, 1);
        chk(tx_ready == 1'b1, "R9", "ready after drop", tx_ready, 1);
        break;
      end
      chk(saw_done == 1'b0 && tx_ready == 1'b0, "R5", "pause keeps busy",
          {saw_done, tx_ready}, 0);
      resends++;
      for (int p = 0; p < 4; p++) begin
        chk(line_drive_low == 1'b0, "R5", "line released in pause", line_drive_low, 0);
        tick1();
      end
    end
    chk(resends <= retries, "R6", "resend count bound", resends, retries);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5C7A_0E13));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(line_drive_low == 1'b0, "R1", "line released", line_drive_low, 0);
    chk(tx_ready == 1'b1, "R1", "ready", tx_ready, 1);
    chk(tx_done == 1'b0, "R1", "done", tx_done, 0);
    chk(tx_err == 1'b0, "R1", "err", tx_err, 0);
    chk(cfg_busy == 1'b0, "R1", "busy", cfg_busy, 0);

    // R2/R3 default T=0 with no error
    send_char(8'hA5, 9'h000);
    send_char(8'h01, 9'h000);
    // R4/R6 retry disabled: error drops at once
    send_char(8'h3C, 9'h001);
    send_char(8'hFF, 9'h000);   // R9 flag persists
    clear_err();

    // R5 two retries, success on third attempt
    cfg_write(1'b0, 1, 1'b0);
    cfg_write(1'b1, 1, 1'b0);
    send_char(8'h96, 9'h003);
    // R7 field write ignored while enabled, stop length still taken
    cfg_write(1'b1, 5, 1'b1);
    send_char(8'h5A, 9'h1FF);
    clear_err();
    // R7 disabling ignores field; then field loads while disabled
    cfg_write(1'b0, 6, 1'b0);
    cfg_write(1'b1, 7, 1'b0);
    send_char(8'h80, 9'h1FF);   // R5 eight resends then drop
    clear_err();
    // R8 write during busy ignored
    cfg_write(1'b0, 0, 1'b0);
    cfg_write_pair(1'b1, 2, 1'b1, 1'b1, 6, 1'b0);
    send_char(8'h7E, 9'h1FF);
    clear_err();

    for (int n = 0; n < 10; n++) begin
      bit en = 1'($urandom);
      int m1 = int'($urandom % 8);
      bit s = 1'($urandom);
      logic [8:0] mask = 9'($urandom & $urandom);
      cfg_write(1'b0, m1, s);
      if (en) cfg_write(1'b1, m1, s);
      send_char(8'($urandom), mask);
      if (m_err) clear_err();
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule